// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a synthesizable behavioural model of a small pipelined synchronous SRAM with registered inputs, a registered data output and per-lane write masking. Every control input is sampled on the rising clock edge. Each edge turns the sampled inputs into one command: start, continue, suspend, deselect or idle. The command is held in a capture register and executed against the array on the following edge. A read therefore appears one full cycle after its address was captured.

An access is started by one of two strobes. The processor strobe always opens a read, and any write in that access happens on a later, strobe-free edge. The controller strobe can write on its own capture edge. While an access is open and no strobe is present, a two-bit wraparound burst counter either holds the current address or advances it. It advances in linear or interleaved order, selected by a static mode input. Writes either cover every lane through a global write input, or pick lanes through a byte-write enable and per-lane selects. Each lane is eight data bits plus one parity bit.

There is no three-state pad. The block instead raises a drive qualifier in every cycle in which a real part would drive the bus. A sleep input stops all activity after two edges, resumes it two edges after release, and keeps the array contents.

Top module: `sync_sram`

## Requirements
- R1: A read command captured on edge k presents the array word on `rdata_o`, with `drive_o` high, after edge k+1. The output enable must be low.
- R2: When `all_wr_ni` is low in a write cycle, all lanes are written, whatever `byte_wr_en_ni` and `lane_sel_ni` are. Lane i occupies bits [9i+8:9i], and bit 9i+8 is its parity bit.
- R3: When `all_wr_ni` is high, lane i is written only if `byte_wr_en_ni` is low and `lane_sel_ni[i]` is low. Other lanes keep their contents. If no lane qualifies, the cycle is a read.
- R4: On the capture edge of an access started by the processor strobe, the write inputs are ignored and a read is started. A write on the next strobe-free edge stores data at the captured address.
- R5: A controller strobe with the processor strobe high, all chip enables active and write inputs active writes on its own capture edge. When both strobes are low with `cs_a_ni` low, only the processor strobe counts.
- R6: `drive_o` is low whenever `oe_ni` is high, and low in the cycle after a write is captured, whatever `oe_ni` is.
- R7: `drive_o` is low in the cycle right after a deselect is captured. A deselect is a strobe seen while the chip enables are not all active. `drive_o` is also low in the first cycle of an access that starts from the deselected state.
- R8: While an access is open and no strobe is present, `adv_ni` low advances the burst counter and `adv_ni` high holds the address. The low two address bits follow start+n mod 4 when `linear_i` is 1, and start XOR n when it is 0.
- R9: A change on `sleep_i` takes effect on the second rising edge after it is sampled. While asleep, commands are ignored, `drive_o` is low and the array keeps its contents.
- R10: A read captured on the edge right after a write to the same address returns the new data.
- R11: The processor strobe is ignored while `cs_a_ni` is high. A controller strobe in that state is a deselect, and it leaves the array unchanged.
- R12: After reset, `drive_o` is low and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address |
| cs_a_ni | input | 1 | Chip enable A, active low; also qualifies the processor strobe |
| cs_b_i | input | 1 | Chip enable B, active high |
| cs_c_ni | input | 1 | Chip enable C, active low |
| proc_strobe_ni | input | 1 | Processor address strobe, active low |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| all_wr_ni | input | 1 | Global write, active low |
| byte_wr_en_ni | input | 1 | Byte-write enable, active low |
| lane_sel_ni | input | LANES | Per-lane write selects, active low |
| oe_ni | input | 1 | Output enable, active low, combinational |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| sleep_i | input | 1 | Sleep request, active high |
| wdata_i | input | 9*LANES | Write data, nine bits per lane |
| rdata_o | output | 9*LANES | Output register contents |
| drive_o | output | 1 | High when the bus would be driven with `rdata_o` |

## Verification
The bound checker examines several properties on every cycle. It checks that the output enable gates `drive_o`, and that a captured write, a deselect or a sleeping state keeps the bus quiet. It checks that every driven cycle follows a captured read. It also checks that the write lane mask matches the global-write and byte-select inputs, and how each strobe is classified when it is captured. Other behaviours are visible only through the data path, so only the bench scenarios can show them. These are burst address order in both modes, lanes left unchanged by partial writes, and pass-through of just-written data. They also include the two-edge sleep latency and the array contents surviving sleep and ignored strobes.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;
endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic              linear_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] next_addr_o
);
  localparam int unsigned HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  base_q;
  logic [CNT_W-1:0] start_q, cnt_q, cnt_nxt, lo_cur, lo_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  // burst order: linear adds the count, interleaved xors it
  always_comb begin
    if (linear_i) begin
      lo_cur = start_q + cnt_q;
      lo_nxt = start_q + cnt_nxt;
    end else begin
      lo_cur = start_q ^ cnt_q;
      lo_nxt = start_q ^ cnt_nxt;
    end
  end

  assign cur_addr_o  = {base_q, lo_cur};
  assign next_addr_o = {base_q, lo_nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      base_q  <= load_addr_i[ADDR_W-1:CNT_W];
      start_q <= load_addr_i[CNT_W-1:0];
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              asleep_i,
  input  logic              active_i,
  input  logic              cs_a_ni,
  input  logic              cs_b_i,
  input  logic              cs_c_ni,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              adv_ni,
  input  logic              all_wr_ni,
  input  logic              byte_wr_en_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  mask_o,
  output logic              load_o,
  output logic              step_o,
  output logic              active_o
);
  logic ce_all, proc_seen, ctrl_seen, start, wr_any;

  assign ce_all    = !cs_a_ni && cs_b_i && !cs_c_ni;
  assign proc_seen = !proc_strobe_ni && !cs_a_ni;
  assign ctrl_seen = !ctrl_strobe_ni && !proc_seen;
  assign start     = proc_seen || ctrl_seen;

  // global write overrides lane selects
  assign mask_o = !all_wr_ni    ? '1 :
                  !byte_wr_en_ni ? ~lane_sel_ni : '0;
  assign wr_any = |mask_o;

  always_comb begin
    op_o     = OP_NOP;
    addr_o   = cur_addr_i;
    load_o   = 1'b0;
    step_o   = 1'b0;
    active_o = active_i;
    if (asleep_i) begin
      active_o = 1'b0;
    end else if (start) begin
      if (!ce_all) begin
        op_o     = OP_DESEL;
        active_o = 1'b0;
      end else begin
        load_o   = 1'b1;
        active_o = 1'b1;
        addr_o   = addr_i;
        op_o     = (ctrl_seen && wr_any) ? OP_WRITE : OP_READ;
      end
    end else if (active_i) begin
      step_o = !adv_ni;
      addr_o = adv_ni ? cur_addr_i : next_addr_i;
      op_o   = wr_any ? OP_WRITE : OP_READ;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  op_e                       op_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES-1:0]          mask_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic                      rvalid_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (op_i == OP_WRITE) begin
      for (int l = 0; l < LANES; l++) begin
        if (mask_i[l]) mem_q[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= (op_i == OP_READ);
      if (op_i == OP_READ) rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/sync_sram.sv
module sync_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    cs_a_ni,
  input  logic                    cs_b_i,
  input  logic                    cs_c_ni,
  input  logic                    proc_strobe_ni,
  input  logic                    ctrl_strobe_ni,
  input  logic                    adv_ni,
  input  logic                    all_wr_ni,
  input  logic                    byte_wr_en_ni,
  input  logic [LANES-1:0]        lane_sel_ni,
  input  logic                    oe_ni,
  input  logic                    linear_i,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [1:0]        zz_q;
  logic              asleep;
  logic              active_q, hold_z_q;
  op_e               op_q, dec_op;
  logic [ADDR_W-1:0] addr_q, dec_addr, cur_addr, next_addr;
  logic [LANES-1:0]  mask_q, dec_mask;
  logic [DATA_W-1:0] wdata_q, arr_rdata;
  logic              dec_load, dec_step, dec_active, arr_valid;

  assign asleep = zz_q[1];

  // two-edge sleep entry and exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zz_q <= '0;
    else         zz_q <= {zz_q[0], sleep_i};
  end

  sram_burst_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (dec_load),
    .load_addr_i (addr_i),
    .step_i      (dec_step),
    .linear_i    (linear_i),
    .cur_addr_o  (cur_addr),
    .next_addr_o (next_addr)
  );

  sram_cmd_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .asleep_i       (asleep),
    .active_i       (active_q),
    .cs_a_ni        (cs_a_ni),
    .cs_b_i         (cs_b_i),
    .cs_c_ni        (cs_c_ni),
    .proc_strobe_ni (proc_strobe_ni),
    .ctrl_strobe_ni (ctrl_strobe_ni),
    .adv_ni         (adv_ni),
    .all_wr_ni      (all_wr_ni),
    .byte_wr_en_ni  (byte_wr_en_ni),
    .lane_sel_ni    (lane_sel_ni),
    .addr_i         (addr_i),
    .cur_addr_i     (cur_addr),
    .next_addr_i    (next_addr),
    .op_o           (dec_op),
    .addr_o         (dec_addr),
    .mask_o         (dec_mask),
    .load_o         (dec_load),
    .step_o         (dec_step),
    .active_o       (dec_active)
  );

  // capture stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_NOP;
      addr_q   <= '0;
      mask_q   <= '0;
      wdata_q  <= '0;
      active_q <= 1'b0;
      hold_z_q <= 1'b1;
    end else begin
      op_q     <= dec_op;
      addr_q   <= dec_addr;
      mask_q   <= (dec_op == OP_WRITE) ? dec_mask : '0;
      wdata_q  <= wdata_i;
      active_q <= dec_active;
      hold_z_q <= (dec_op != OP_READ);
    end
  end

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op_q),
    .addr_i   (addr_q),
    .mask_i   (mask_q),
    .wdata_i  (wdata_q),
    .rdata_o  (arr_rdata),
    .rvalid_o (arr_valid)
  );

  assign rdata_o = arr_rdata;
  assign drive_o = arr_valid && !hold_z_q && !asleep && !oe_ni;
endmodule

// File: rtl/sync_sram_chk.sv
module sync_sram_chk
  import sram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             oe_ni,
  input logic             drive_o,
  input logic             all_wr_ni,
  input logic             byte_wr_en_ni,
  input logic [LANES-1:0] lane_sel_ni,
  input logic             proc_strobe_ni,
  input logic             ctrl_strobe_ni,
  input logic             cs_a_ni,
  input logic             cs_b_i,
  input logic             cs_c_ni,
  input logic [1:0]       op_q,
  input logic [LANES-1:0] mask_q,
  input logic             asleep
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_read_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    drive_o |-> $past(op_q == OP_READ));

  p_gw_all_lanes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (op_q == OP_WRITE && $past(!all_wr_ni)) |-> (mask_q == '1));

  p_lane_select_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (op_q == OP_WRITE && $past(all_wr_ni)) |->
      (mask_q == ~$past(lane_sel_ni)) && !$past(byte_wr_en_ni));

  p_proc_start_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(!proc_strobe_ni && !cs_a_ni && cs_b_i && !cs_c_ni && !asleep) |-> (op_q == OP_READ));

  p_ctrl_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(proc_strobe_ni && !ctrl_strobe_ni && !cs_a_ni && cs_b_i && !cs_c_ni && !asleep &&
          (!all_wr_ni || (!byte_wr_en_ni && !(&lane_sel_ni)))) |-> (op_q == OP_WRITE));

  p_oe_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> !oe_ni);

  p_write_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_WRITE) |-> !drive_o);

  p_desel_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_DESEL) |-> !drive_o);

  p_sleep_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep |-> !drive_o);
endmodule

bind sync_sram sync_sram_chk #(.LANES(LANES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .oe_ni          (oe_ni),
  .drive_o        (drive_o),
  .all_wr_ni      (all_wr_ni),
  .byte_wr_en_ni  (byte_wr_en_ni),
  .lane_sel_ni    (lane_sel_ni),
  .proc_strobe_ni (proc_strobe_ni),
  .ctrl_strobe_ni (ctrl_strobe_ni),
  .cs_a_ni        (cs_a_ni),
  .cs_b_i         (cs_b_i),
  .cs_c_ni        (cs_c_ni),
  .op_q           (op_q),
  .mask_q         (mask_q),
  .asleep         (asleep)
);

// File: tb/sim_sync_sram.sv
module sim_sync_sram;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = LANES * 9;

  // {addr, data, all_wr_n, byte_wr_en_n, lane_sel_n}
  localparam logic [47:0] VEC [8] = '{
    {6'd5,  36'h123456789, 1'b0, 1'b1, 4'hF},
    {6'd9,  36'hABCDEF012, 1'b0, 1'b1, 4'hF},
    {6'd5,  36'hFFFFFFFFF, 1'b1, 1'b0, 4'hE},
    {6'd9,  36'h000000000, 1'b1, 1'b0, 4'h5},
    {6'd5,  36'h555555555, 1'b1, 1'b1, 4'h0},
    {6'd9,  36'h3C3C3C3C3, 1'b0, 1'b1, 4'hF},
    {6'd20, 36'h0F0F0F0F0, 1'b0, 1'b0, 4'hF},
    {6'd20, 36'h987654321, 1'b1, 1'b0, 4'h0}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              cs_a_ni = 1'b1, cs_b_i = 1'b1, cs_c_ni = 1'b0;
  logic              proc_strobe_ni = 1'b1, ctrl_strobe_ni = 1'b1, adv_ni = 1'b1;
  logic              all_wr_ni = 1'b1, byte_wr_en_ni = 1'b1;
  logic [LANES-1:0]  lane_sel_ni = '1;
  logic              oe_ni = 1'b0, linear_i = 1'b1, sleep_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              drive_o;

  logic [DATA_W-1:0] ref_mem [1 << ADDR_W];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  sync_sram u0 (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_idle();
    cs_a_ni = 1'b1; cs_b_i = 1'b1; cs_c_ni = 1'b0;
    proc_strobe_ni = 1'b1; ctrl_strobe_ni = 1'b1; adv_ni = 1'b1;
    all_wr_ni = 1'b1; byte_wr_en_ni = 1'b1; lane_sel_ni = '1;
  endtask

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old, input logic [DATA_W-1:0] nw,
                                              input logic gw_n, input logic bwe_n, input logic [LANES-1:0] sel_n);
    logic [DATA_W-1:0] r = old;
    for (int l = 0; l < LANES; l++)
      if (!gw_n || (!bwe_n && !sel_n[l])) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic ctrl_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic gw_n, input logic bwe_n, input logic [LANES-1:0] sel_n);
    set_idle();
    cs_a_ni = 1'b0; ctrl_strobe_ni = 1'b0; addr_i = a; wdata_i = d;
    all_wr_ni = gw_n; byte_wr_en_ni = bwe_n; lane_sel_ni = sel_n;
    step();
    ref_mem[a] = merge(ref_mem[a], d, gw_n, bwe_n, sel_n);
    set_idle();
  endtask

  task automatic proc_rd(input logic [ADDR_W-1:0] a);
    set_idle();
    cs_a_ni = 1'b0; proc_strobe_ni = 1'b0; addr_i = a;
    step();
    set_idle();
  endtask

  task automatic hold();
    set_idle();
    step();
  endtask

  task automatic read_check(input logic [ADDR_W-1:0] a, input string tag);
    proc_rd(a);
    hold();
    chk(drive_o === 1'b1, {tag, " drive"}, 64'(drive_o), 64'd1);
    chk(rdata_o === ref_mem[a], {tag, " data"}, 64'(rdata_o), 64'(ref_mem[a]));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk(drive_o === 1'b0, "R12 reset drive", 64'(drive_o), 64'd0);
    hold();
    chk(drive_o === 1'b0, "R12 idle after reset", 64'(drive_o), 64'd0);

    // table walk: R2 / R3 writes, each read back
    for (int i = 0; i < 8; i++) begin
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      logic g, b;
      logic [LANES-1:0] s;
      {a, d, g, b, s} = VEC[i];
      ctrl_wr(a, d, g, b, s);
      read_check(a, g ? "R3 byte write" : "R2 global write");
    end

    // R7 / R1: deselect, then first cycle quiet, then data
    proc_rd(5);
    hold();
    chk(drive_o === 1'b1, "R1 read drive", 64'(drive_o), 64'd1);
    cs_a_ni = 1'b0; proc_strobe_ni = 1'b0; cs_b_i = 1'b0;
    step();
    set_idle();
    chk(drive_o === 1'b0, "R7 deselect immediate", 64'(drive_o), 64'd0);
    hold();
    proc_rd(5);
    chk(drive_o === 1'b0, "R7 first cycle quiet", 64'(drive_o), 64'd0);
    hold();
    chk(rdata_o === ref_mem[5], "R1 latency data", 64'(rdata_o), 64'(ref_mem[5]));

    // R6 output enable and write cycles
    oe_ni = 1'b1; #1;
    chk(drive_o === 1'b0, "R6 oe high", 64'(drive_o), 64'd0);
    oe_ni = 1'b0; #1;
    chk(drive_o === 1'b1, "R6 oe low", 64'(drive_o), 64'd1);
    ctrl_wr(44, 36'h1A2B3C4D5, 1'b0, 1'b1, '1);
    chk(drive_o === 1'b0, "R6 write quiet", 64'(drive_o), 64'd0);
    read_check(44, "R10 pass-through");

    // R5 controller write single cycle, processor priority
    ctrl_wr(48, 36'h777000777, 1'b0, 1'b1, '1);
    read_check(48, "R5 ctrl write");
    ctrl_wr(40, 36'h246813579, 1'b0, 1'b1, '1);
    set_idle();
    cs_a_ni = 1'b0; proc_strobe_ni = 1'b0; ctrl_strobe_ni = 1'b0;
    addr_i = 40; wdata_i = 36'hDEADDEAD0; all_wr_ni = 1'b0;
    step();
    hold();
    chk(rdata_o === ref_mem[40], "R5 processor priority", 64'(rdata_o), 64'(ref_mem[40]));

    // R4 processor-started write lands on the next edge
    ctrl_wr(30, 36'h111222333, 1'b0, 1'b1, '1);
    set_idle();
    cs_a_ni = 1'b0; proc_strobe_ni = 1'b0; addr_i = 30;
    wdata_i = 36'hEEEEEEEEE; all_wr_ni = 1'b0;
    step();
    set_idle();
    wdata_i = 36'h0000001AB; byte_wr_en_ni = 1'b0; lane_sel_ni = 4'hE;
    step();
    ref_mem[30] = merge(ref_mem[30], 36'h0000001AB, 1'b1, 1'b0, 4'hE);
    set_idle();
    read_check(30, "R4 processor write");

    // R11 processor strobe ignored with cs_a high
    proc_rd(5);
    set_idle();
    proc_strobe_ni = 1'b0; addr_i = 9;
    step();
    hold();
    chk(rdata_o === ref_mem[5], "R11 proc ignored", 64'(rdata_o), 64'(ref_mem[5]));
    set_idle();
    ctrl_strobe_ni = 1'b0; addr_i = 5; wdata_i = 36'hBADBADBAD; all_wr_ni = 1'b0;
    step();
    chk(drive_o === 1'b0, "R11 ctrl deselect", 64'(drive_o), 64'd0);
    set_idle();
    all_wr_ni = 1'b0;
    step();
    set_idle();
    read_check(5, "R11 array unchanged");

    // R8 bursts in both orders
    for (int i = 0; i < 4; i++) ctrl_wr(6'h10 + 6'(i), 36'hA00000000 + 36'(i * 36'h1111), 1'b0, 1'b1, '1);
    for (int m = 0; m < 2; m++) begin
      linear_i = (m == 0);
      proc_rd(6'h11);
      for (int j = 0; j < 4; j++) begin
        logic [1:0] lo;
        lo = (m == 0) ? 2'(1 + j) : (2'd1 ^ 2'(j));
        set_idle();
        adv_ni = (j < 3) ? 1'b0 : 1'b1;
        step();
        chk(rdata_o === ref_mem[{4'b0100, lo}], m == 0 ? "R8 linear order" : "R8 interleaved order",
            64'(rdata_o), 64'(ref_mem[{4'b0100, lo}]));
      end
      hold();
      chk(rdata_o === ref_mem[{4'b0100, (m == 0) ? 2'd0 : 2'd2}], "R8 advance held",
          64'(rdata_o), 64'(ref_mem[{4'b0100, (m == 0) ? 2'd0 : 2'd2}]));
    end
    linear_i = 1'b1;

    // R9 sleep entry and exit
    proc_rd(5);
    hold();
    sleep_i = 1'b1;
    hold();
    chk(drive_o === 1'b1, "R9 first edge still awake", 64'(drive_o), 64'd1);
    hold();
    chk(drive_o === 1'b0, "R9 asleep quiet", 64'(drive_o), 64'd0);
    set_idle();
    cs_a_ni = 1'b0; ctrl_strobe_ni = 1'b0; addr_i = 5; wdata_i = 36'h999999999; all_wr_ni = 1'b0;
    step();
    hold();
    sleep_i = 1'b0;
    hold();
    chk(drive_o === 1'b0, "R9 exit first edge", 64'(drive_o), 64'd0);
    proc_rd(5);
    hold();
    chk(drive_o === 1'b0, "R9 exit second edge ignored", 64'(drive_o), 64'd0);
    read_check(5, "R9 contents kept");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule